// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Setting Store

This block sits behind a serial command front end and owns all the state of a 1024-position digital potentiometer. It holds a volatile 10-bit wiper register, which sets the live tap position. It also holds four 10-bit setting registers that stand in for retained storage. The front end decodes each frame into a single command pulse and reports the end of every frame, saying whether the frame was received in full. The block then moves values among the host, the wiper and the setting registers, and it answers reads with a one-cycle response.

Writes to the setting registers are not applied at once. Such a write is held until the frame closes cleanly with the write-protect input high. The block then raises a busy flag for a programmable number of cycles, and the new value lands when that period ends. A change of wiper value reaches the tap output only after a programmable response delay. The tap output is a registered one-hot vector of 1024 lines.

There are two resets. A power-on reset loads the setting registers from a parameter. A warm reset leaves the setting registers intact. Both resets recall setting register 0 into the wiper.

Top module: `pot_ctrl`

## Requirements
- R1: While `por` is high, the setting registers load from `DR_INIT`, with register n taken from bits [10n+9:10n]. In the cycle after `por` falls, `wip` and `rd_valid` are 0, and `wiper_pos` equals register 0 of `DR_INIT`.
- R2: A warm reset (`rst` high, `por` low) leaves all four setting registers unchanged. It sets the wiper register and `wiper_pos` to the current contents of setting register 0.
- R3: `tap_sel` always has exactly one bit set, and that bit is bit `wiper_pos`. A position of 0x000 drives bit 0 and a position of 0x3FF drives bit 1023.
- R4: Op 1 (write wiper) stores `cmd_data` in the wiper register. A read of the wiper issued in the next cycle returns the new value. `wiper_pos` and `tap_sel` change exactly `RESP_CYC` cycles after the command cycle, and not before.
- R5: Op 4 (setting to wiper) copies setting register `cmd_ptr` into the wiper register, with the same `RESP_CYC` delay before the tap changes.
- R6: Op 0 (read wiper), op 2 (read setting `cmd_ptr`) and op 6 (read status) raise `rd_valid` for one cycle, in the cycle after the command. For op 6, `rd_data` carries `wip` in bit 0 and zeros in bits 9:1.
- R7: Op 3 (write setting) and op 5 (wiper to setting) change no setting register before `frame_end`. Reads of the target return the old value until the busy period has ended.
- R8: A commit happens when `frame_end` arrives with `frame_ok`=1, `wp_n`=1 and a held write. On a commit, `wip` is 1 for exactly `BUSY_CYC` cycles, beginning the cycle after `frame_end`. When `wip` falls, the target register holds the new value.
- R9: If `wp_n` is 0 when `frame_end` arrives, the held write is dropped. `wip` stays 0 and no setting register changes.
- R10: While `wip` is 1, ops 3 and 5 are discarded and leave no held write behind, but read commands are still answered.
- R11: A `frame_end` with `frame_ok`=0 drops any held write. `wip` stays 0 and no setting register changes. A later clean `frame_end` commits nothing.
- R12: Op 5 captures the wiper value present at the command cycle. A wiper write between that command and `frame_end` does not change what is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high; setting registers retained |
| por | input | 1 | Synchronous power-on reset, active high; loads `DR_INIT` |
| wp_n | input | 1 | Write enable for setting registers, low blocks commits |
| cmd_valid | input | 1 | One-cycle pulse carrying a decoded command |
| cmd_op | input | 3 | Command code (0..6 as in the requirements, 7 = no-op) |
| cmd_ptr | input | PTR_W (2) | Setting register index |
| cmd_data | input | DATA_W (10) | Value for write commands |
| frame_end | input | 1 | One-cycle pulse when the frame closes |
| frame_ok | input | 1 | Frame was received in full (valid with `frame_end`) |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | DATA_W (10) | Read response value |
| wip | output | 1 | Setting register write in progress |
| wiper_pos | output | DATA_W (10) | Tap position currently applied |
| tap_sel | output | 2**DATA_W (1024) | One-hot tap select |

## Verification
The assertions assume the following about the front end. It delivers at most one command per frame. `cmd_valid` and `frame_end` are single-cycle pulses that never coincide. `cmd_op` holds a defined code whenever `cmd_valid` is high. The stimulus always issues a command and its closing `frame_end` in separate cycles, and it changes `wp_n` only while neither pulse is active. Busy and response delays are shortened through parameters, so that each random frame can wait out its full busy period before the next one begins. A few frames are placed on purpose inside a busy period.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIPER    = 3'd0,
    OP_WR_WIPER    = 3'd1,
    OP_RD_REG      = 3'd2,
    OP_WR_REG      = 3'd3,
    OP_REG_TO_WIPER = 3'd4,
    OP_WIPER_TO_REG = 3'd5,
    OP_RD_STATUS   = 3'd6,
    OP_NONE        = 3'd7
  } pot_op_e;

  function automatic logic op_is_read(input pot_op_e op);
    return (op == OP_RD_WIPER) || (op == OP_RD_REG) || (op == OP_RD_STATUS);
  endfunction
endpackage

// File: rtl/pot_cmd.sv
module pot_cmd
  import pot_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] wcr,
  input  logic [DATA_W-1:0] reg_rd,
  input  logic              wip,
  output logic              wiper_load,
  output logic [DATA_W-1:0] wiper_val,
  output logic              nv_req,
  output logic [DATA_W-1:0] nv_val,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  pot_op_e op;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    op         = pot_op_e'(cmd_op);
    wiper_load = cmd_valid && (op == OP_WR_WIPER || op == OP_REG_TO_WIPER);
    wiper_val  = (op == OP_WR_WIPER) ? cmd_data : reg_rd;
    nv_req     = cmd_valid && (op == OP_WR_REG || op == OP_WIPER_TO_REG);
    nv_val     = (op == OP_WR_REG) ? cmd_data : wcr;
    case (op)
      OP_RD_WIPER:  rd_next = wcr;
      OP_RD_REG:    rd_next = reg_rd;
      OP_RD_STATUS: rd_next = {{(DATA_W-1){1'b0}}, wip};
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_valid && op_is_read(op);
      if (cmd_valid && op_is_read(op)) rd_data <= rd_next;
    end
  end

  // R6: a response only follows a read command one cycle earlier
  assert_rd_follows_cmd_R6: assert property (@(posedge clk) disable iff (rst || por)
    rd_valid |-> $past(cmd_valid && op_is_read(op)));

  // R6: status responses carry only the busy bit
  assert_status_format_R6: assert property (@(posedge clk) disable iff (rst || por)
    (cmd_valid && op == OP_RD_STATUS) |=> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/pot_nv_store.sv
module pot_nv_store #(
  parameter int DATA_W   = 10,
  parameter int NREG     = 4,
  parameter int BUSY_CYC = 500000,
  parameter logic [NREG*DATA_W-1:0] DR_INIT = '0,
  localparam int PTR_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wp_n,
  input  logic              nv_req,
  input  logic [PTR_W-1:0]  nv_ptr,
  input  logic [DATA_W-1:0] nv_val,
  input  logic              frame_end,
  input  logic              frame_ok,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] dr0,
  output logic              wip
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] BUSY_LD = CNT_W'(BUSY_CYC);

  logic [DATA_W-1:0] regs [NREG];
  logic [NREG*DATA_W-1:0] regs_flat;

  logic              pend_v;
  logic [PTR_W-1:0]  pend_ptr;
  logic [DATA_W-1:0] pend_val;
  logic [PTR_W-1:0]  com_ptr;
  logic [DATA_W-1:0] com_val;
  logic [CNT_W-1:0]  busy_cnt;
  logic              commit_go;
  logic              commit_done;

  assign commit_go   = frame_end && frame_ok && wp_n && pend_v && !wip;
  assign commit_done = wip && (busy_cnt == CNT_W'(1));

  // single write port, one read port
  always_ff @(posedge clk) begin
    if (por) begin
      for (int i = 0; i < NREG; i++) regs[i] <= DR_INIT[i*DATA_W +: DATA_W];
    end else if (!rst && commit_done) begin
      regs[com_ptr] <= com_val;
    end
  end

  assign rd_val = regs[rd_ptr];
  assign dr0    = regs[0];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || por) begin
      pend_v   <= 1'b0;
      pend_ptr <= '0;
      pend_val <= '0;
      com_ptr  <= '0;
      com_val  <= '0;
      busy_cnt <= '0;
      wip      <= 1'b0;
    end else begin
      if (frame_end) begin
        pend_v <= 1'b0;
        if (commit_go) begin
          wip      <= 1'b1;
          busy_cnt <= BUSY_LD;
          com_ptr  <= pend_ptr;
          com_val  <= pend_val;
        end
      end else if (nv_req && !wip) begin
        pend_v   <= 1'b1;
        pend_ptr <= nv_ptr;
        pend_val <= nv_val;
      end
      if (wip) begin
        busy_cnt <= busy_cnt - CNT_W'(1);
        if (commit_done) wip <= 1'b0;
      end
    end
  end

  // R9: write protect low at frame close starts no busy period
  assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (rst || por)
    (frame_end && !wp_n && !wip) |=> !wip);

  // R11: an incomplete frame starts no busy period
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst || por)
    (frame_end && !frame_ok && !wip) |=> !wip);

  // R7: outside a busy period the setting registers never move
  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (rst || por)
    !wip |=> $stable(regs_flat));

  // R8: a busy period starts with the full count and does not end early
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst || por)
    $rose(wip) |-> (busy_cnt == BUSY_LD));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst || por)
    (wip && busy_cnt > CNT_W'(1)) |=> wip);

  // R10: nothing is held for commit while busy
  assert_discard_busy_R10: assert property (@(posedge clk) disable iff (rst || por)
    (wip && nv_req) |=> !pend_v);
endmodule

// File: rtl/pot_wiper.sv
module pot_wiper #(
  parameter int DATA_W   = 10,
  parameter int RESP_CYC = 250,
  localparam int TAPS    = 1 << DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [DATA_W-1:0] recall_val,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] wcr,
  output logic [DATA_W-1:0] pos,
  output logic [TAPS-1:0]   tap_sel
);
  localparam int RC_W = $clog2(RESP_CYC + 1);
  localparam logic [RC_W-1:0] RESP_LD = RC_W'(RESP_CYC);

  logic [RC_W-1:0]   cnt;
  logic              upd;
  logic [DATA_W-1:0] nxt_pos;
  logic [TAPS-1:0]   dec;

  always_comb begin
    if (rst || por) begin
      upd     = 1'b1;
      nxt_pos = recall_val;
    end else if (!load && cnt == RC_W'(1)) begin
      upd     = 1'b1;
      nxt_pos = wcr;
    end else begin
      upd     = 1'b0;
      nxt_pos = pos;
    end
  end

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_dec
      assign dec[g] = (nxt_pos == DATA_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (upd) begin
      pos     <= nxt_pos;
      tap_sel <= dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      wcr <= recall_val;
      cnt <= '0;
    end else if (load) begin
      wcr <= load_val;
      cnt <= RESP_LD;
    end else if (cnt != '0) begin
      cnt <= cnt - RC_W'(1);
    end
  end

  // R3: exactly one tap line, and it is the applied position
  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst || por)
    $countones(tap_sel) == 1);
  assert_tap_matches_R3: assert property (@(posedge clk) disable iff (rst || por)
    tap_sel[pos] == 1'b1);

  // R4: a new load never reaches the tap in the following cycle
  assert_no_early_move_R4: assert property (@(posedge clk) disable iff (rst || por)
    load |=> $stable(pos));

  // R4: with no delay running the applied position is stable
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst || por)
    (!load && cnt == '0) |=> $stable(pos));
endmodule

// File: rtl/pot_ctrl.sv
module pot_ctrl #(
  parameter int DATA_W   = 10,
  parameter int NREG     = 4,
  parameter int BUSY_CYC = 500000,
  parameter int RESP_CYC = 250,
  parameter logic [NREG*DATA_W-1:0] DR_INIT = '0,
  localparam int PTR_W   = $clog2(NREG),
  localparam int TAPS    = 1 << DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              frame_end,
  input  logic              frame_ok,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wip,
  output logic [DATA_W-1:0] wiper_pos,
  output logic [TAPS-1:0]   tap_sel
);
  logic [DATA_W-1:0] wcr;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] dr0;
  logic [DATA_W-1:0] recall_val;
  logic              wiper_load;
  logic [DATA_W-1:0] wiper_val;
  logic              nv_req;
  logic [DATA_W-1:0] nv_val;

  // power-on recall takes the initial image, warm reset the live register
  assign recall_val = por ? DR_INIT[DATA_W-1:0] : dr0;

  pot_cmd #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_cmd (
    .clk(clk), .rst(rst), .por(por),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .wcr(wcr), .reg_rd(reg_rd), .wip(wip),
    .wiper_load(wiper_load), .wiper_val(wiper_val),
    .nv_req(nv_req), .nv_val(nv_val),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pot_nv_store #(.DATA_W(DATA_W), .NREG(NREG), .BUSY_CYC(BUSY_CYC), .DR_INIT(DR_INIT)) u_store (
    .clk(clk), .rst(rst), .por(por), .wp_n(wp_n),
    .nv_req(nv_req), .nv_ptr(cmd_ptr), .nv_val(nv_val),
    .frame_end(frame_end), .frame_ok(frame_ok),
    .rd_ptr(cmd_ptr), .rd_val(reg_rd), .dr0(dr0), .wip(wip)
  );

  pot_wiper #(.DATA_W(DATA_W), .RESP_CYC(RESP_CYC)) u_wiper (
    .clk(clk), .rst(rst), .por(por), .recall_val(recall_val),
    .load(wiper_load), .load_val(wiper_val),
    .wcr(wcr), .pos(wiper_pos), .tap_sel(tap_sel)
  );

  // R2: after a warm reset the wiper shows setting register 0
  assert_warm_recall_R2: assert property (@(posedge clk) disable iff (por)
    (rst && !por) |=> (wiper_pos == $past(dr0)));
endmodule

// File: tb/pot_ctrl_tb.sv
module pot_ctrl_tb;
  localparam int W = 10;
  localparam int NREG = 4;
  localparam int PW = 2;
  localparam int BUSY = 40;
  localparam int RESP = 6;
  localparam int TAPS = 1 << W;
  localparam logic [NREG*W-1:0] INIT = {10'h155, 10'h0AA, 10'h3FF, 10'h123};

  logic clk = 1'b0;
  logic rst = 1'b1, por = 1'b1, wp_n = 1'b1;
  logic cmd_valid = 1'b0, frame_end = 1'b0, frame_ok = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [PW-1:0] cmd_ptr = '0;
  logic [W-1:0] cmd_data = '0;
  logic rd_valid, wip;
  logic [W-1:0] rd_data, wiper_pos;
  logic [TAPS-1:0] tap_sel;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] dr_m [NREG];
  logic [W-1:0] wcr_m;

  always #10 clk = ~clk;

  pot_ctrl #(.DATA_W(W), .NREG(NREG), .BUSY_CYC(BUSY), .RESP_CYC(RESP), .DR_INIT(INIT)) u_dut (
    .clk(clk), .rst(rst), .por(por), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr), .cmd_data(cmd_data),
    .frame_end(frame_end), .frame_ok(frame_ok),
    .rd_valid(rd_valid), .rd_data(rd_data), .wip(wip),
    .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [PW-1:0] ptr, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ptr = ptr; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic close_frame(input logic ok);
    @(negedge clk);
    frame_end = 1'b1; frame_ok = ok;
    @(negedge clk);
    frame_end = 1'b0; frame_ok = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] op, input logic [PW-1:0] ptr,
                          input logic [W-1:0] exp, input string tag);
    issue(op, ptr, '0);
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk({tag, " rd_data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic tap_chk(input logic [W-1:0] exp, input string tag);
    chk({tag, " wiper_pos"}, 32'(wiper_pos), 32'(exp));
    chk("R3 tap bit", 32'(tap_sel[exp]), 32'd1);
    chk("R3 tap count", 32'($countones(tap_sel)), 32'd1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    wait_cyc(4);
    rst = 1'b0; por = 1'b0;
    @(negedge clk);
    // R1 power-on state
    chk("R1 wip", 32'(wip), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    tap_chk(10'h123, "R1");
    read_chk(3'd2, 2'd0, 10'h123, "R1 dr0");
    read_chk(3'd2, 2'd1, 10'h3FF, "R1 dr1");
    read_chk(3'd2, 2'd2, 10'h0AA, "R1 dr2");
    read_chk(3'd2, 2'd3, 10'h155, "R1 dr3");

    // R4 response delay and low-end tap
    issue(3'd1, 2'd0, 10'h000);
    wait_cyc(RESP - 1);
    chk("R4 not yet", 32'(wiper_pos), 32'h123);
    wait_cyc(1);
    tap_chk(10'h000, "R4");
    // R4 read-back next cycle, high-end tap
    issue(3'd1, 2'd0, 10'h3FF);
    read_chk(3'd0, 2'd0, 10'h3FF, "R4 wcr");
    chk("R4 pos old", 32'(wiper_pos), 32'h000);
    wait_cyc(RESP);
    tap_chk(10'h3FF, "R3");

    // R7/R8 deferred commit and busy length
    issue(3'd3, 2'd2, 10'h2A5);
    read_chk(3'd2, 2'd2, 10'h0AA, "R7 before close");
    close_frame(1'b1);
    chk("R8 wip rises", 32'(wip), 32'd1);
    n = 0;
    while (wip === 1'b1) begin n++; @(negedge clk); end
    chk("R8 busy length", 32'(n), 32'(BUSY));
    read_chk(3'd2, 2'd2, 10'h2A5, "R8 committed");

    // R10 reads during busy, writes discarded
    issue(3'd3, 2'd3, 10'h2F0);
    close_frame(1'b1);
    read_chk(3'd6, 2'd0, 10'h001, "R6 status busy");
    read_chk(3'd2, 2'd3, 10'h155, "R10 read old while busy");
    issue(3'd3, 2'd1, 10'h011);
    close_frame(1'b1);
    wait_cyc(BUSY + 2);
    chk("R10 wip idle", 32'(wip), 32'd0);
    read_chk(3'd2, 2'd3, 10'h2F0, "R10 first write");
    read_chk(3'd2, 2'd1, 10'h3FF, "R10 discarded");
    read_chk(3'd6, 2'd0, 10'h000, "R6 status idle");

    // R9 write protect
    wp_n = 1'b0;
    issue(3'd3, 2'd0, 10'h0F0);
    close_frame(1'b1);
    chk("R9 wip", 32'(wip), 32'd0);
    wp_n = 1'b1;
    wait_cyc(BUSY + 2);
    read_chk(3'd2, 2'd0, 10'h123, "R9 dr0 kept");

    // R11 aborted frame
    issue(3'd3, 2'd3, 10'h001);
    close_frame(1'b0);
    chk("R11 wip", 32'(wip), 32'd0);
    close_frame(1'b1);
    chk("R11 nothing held", 32'(wip), 32'd0);
    read_chk(3'd2, 2'd3, 10'h2F0, "R11 dr3 kept");

    // R12 capture at command time
    issue(3'd1, 2'd0, 10'h1C7);
    issue(3'd5, 2'd0, 10'h000);
    issue(3'd1, 2'd0, 10'h050);
    close_frame(1'b1);
    wait_cyc(BUSY + 2);
    read_chk(3'd2, 2'd0, 10'h1C7, "R12 dr0");

    // R5 setting to wiper
    issue(3'd4, 2'd2, 10'h000);
    wait_cyc(RESP - 1);
    chk("R5 not yet", 32'(wiper_pos), 32'h050);
    wait_cyc(1);
    tap_chk(10'h2A5, "R5");

    // R2 warm reset
    @(negedge clk); rst = 1'b1;
    wait_cyc(2); rst = 1'b0;
    @(negedge clk);
    tap_chk(10'h1C7, "R2");
    read_chk(3'd0, 2'd0, 10'h1C7, "R2 wcr");
    read_chk(3'd2, 2'd2, 10'h2A5, "R2 dr2 kept");
    read_chk(3'd2, 2'd3, 10'h2F0, "R2 dr3 kept");

    // random phase against a bench model
    dr_m[0] = 10'h1C7; dr_m[1] = 10'h3FF; dr_m[2] = 10'h2A5; dr_m[3] = 10'h2F0;
    wcr_m = 10'h1C7;
    for (int it = 0; it < 80; it++) begin
      logic [2:0] op;
      logic [PW-1:0] p;
      logic [W-1:0] d, v;
      logic wpr, okr;
      op  = 3'($urandom_range(0, 6));
      p   = PW'($urandom_range(0, NREG - 1));
      d   = W'($urandom_range(0, TAPS - 1));
      wpr = ($urandom_range(0, 3) != 0);
      okr = ($urandom_range(0, 3) != 0);
      case (op)
        3'd0: read_chk(op, p, wcr_m, "R6 rand wiper");
        3'd2: read_chk(op, p, dr_m[p], "R6 rand reg");
        3'd6: read_chk(op, p, 10'h000, "R6 rand status");
        3'd1, 3'd4: begin
          v = (op == 3'd1) ? d : dr_m[p];
          issue(op, p, d);
          wcr_m = v;
          close_frame(1'b1);
          wait_cyc(RESP);
          tap_chk(wcr_m, (op == 3'd1) ? "R4 rand" : "R5 rand");
        end
        default: begin
          v = (op == 3'd3) ? d : wcr_m;
          issue(op, p, d);
          wp_n = wpr;
          close_frame(okr);
          wp_n = 1'b1;
          chk("R8 R9 R11 rand wip", 32'(wip), 32'(okr && wpr));
          if (okr && wpr) dr_m[p] = v;
          wait_cyc(BUSY + 1);
          chk("R8 rand idle", 32'(wip), 32'd0);
        end
      endcase
    end
    for (int i = 0; i < NREG; i++) read_chk(3'd2, PW'(i), dr_m[i], "R7 final reg");
    read_chk(3'd0, 2'd0, wcr_m, "R4 final wiper");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule